// File: doc/BRIEF.md
# Asynchronous Flag-Delimited Frame Receiver

This block sits behind a UART-style deserializer. The deserializer hands over one complete character per strobe. Each character comes with a framing-error indication and the three majority-vote samples taken for it. The receiver looks for the flag character 0x7E and treats everything between an opening flag and the next flag as one frame. It writes every frame byte into a receive buffer through a simple byte write port, at addresses that start from zero for each frame. When the frame ends it gives a one-cycle frame-done pulse carrying the byte count and two error flags.

There is no length limit: however long a frame runs, every byte is stored and counted. A frame is cut short in two cases: the carrier-present input drops, or a character arrives marked with a framing error. In either case the character that was in progress is thrown away, so the reported count always matches the number of writes made. Disagreement among the three vote samples is ignored on purpose, because data integrity is left to a CRC further downstream. No error counters are kept.

The controller has three states:
- `ST_HUNT`: waiting for an opening flag.
- `ST_OPEN`: a flag has been seen and no data has arrived yet.
- `ST_DATA`: collecting bytes.

Its transitions are:
- hunt-to-open on a clean flag while the carrier is present.
- open-to-open on a repeated flag.
- open-to-data on the first data byte, which is also written.
- data-to-data on each further byte.
- data-to-open on a closing flag, which reports a clean frame.
- data-to-hunt on carrier loss or a framing error, which reports an error frame.
- open-to-hunt on carrier loss or a framing error, with no report.

Top module: `afr_rx`

## Requirements
- R1: After reset, wr_en, done, done_count, done_cd_err and done_fr_err are all 0.
- R2: Characters received in ST_HUNT, including after an error-ended frame, produce no write and no done pulse until a flag (0x7E) with carrier present opens a frame.
- R3: Consecutive flags (0x7E) with no data between them produce no done pulse and no write, so no zero-length frame is reported.
- R4: Each data byte of a frame is written one cycle after its strobe, with wr_data equal to the byte and wr_addr equal to its zero-based position in the frame.
- R5: A closing flag raises done one cycle after its strobe, with done_count equal to the number of bytes written for that frame and both error flags at 0.
- R6: A closing flag also opens the next frame: bytes that follow it directly are written starting again at address 0, and their count starts again from 0.
- R7: A byte whose three vote samples disagree is written and counted exactly like any other byte, and no flag reports it.
- R8: If carrier_ok is low during ST_DATA, the frame closes that cycle with done_cd_err=1 and the count of bytes already written. A character strobed in the same cycle is not written. While carrier_ok is low, no write occurs.
- R9: A character strobed with chr_ferr=1 is never written. In ST_DATA it closes the frame with done_fr_err=1 and the count of bytes already written.
- R10: A frame of any length, including one longer than any nominal maximum, has all its bytes written and counted. No length check exists.
- R11: A flag received while carrier_ok is low does not open a frame.
- R12: done is high for exactly one cycle per closed frame, and at most one of done_cd_err and done_fr_err is set, only while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | One-cycle strobe: a character is complete |
| chr_data | input | 8 | Character value |
| chr_ferr | input | 1 | Framing error on this character |
| chr_votes | input | 3 | Three vote samples of the character (ignored) |
| carrier_ok | input | 1 | Carrier present (active high) |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | AW | Byte address within the frame |
| wr_data | output | 8 | Byte to write |
| done | output | 1 | One-cycle frame-done pulse |
| done_count | output | CW | Bytes written for the closed frame |
| done_cd_err | output | 1 | Frame ended by carrier loss |
| done_fr_err | output | 1 | Frame ended by a framing error |

## Verification
On every cycle, the assertions check the following:
- the one-cycle width of done and the exclusive, pulse-qualified error flags;
- that consecutive writes step the address by one;
- that no write follows a framing-error character or a cycle without carrier;
- that a data byte in ST_DATA is written whatever its vote samples.

Only the bench scenarios can show that a frame closes with the exact count of bytes written. The same holds for the following:
- frame boundaries restarting the address at zero;
- back-to-back flags staying silent;
- data outside a frame being dropped;
- a long frame being stored in full.

// File: rtl/afr_pkg.sv
package afr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_OPEN = 2'd1,
        ST_DATA = 2'd2
    } afr_state_e;

    localparam logic [7:0] FLAG_CHAR = 8'h7E;
endpackage

// File: rtl/afr_classify.sv
module afr_classify
    import afr_pkg::*;
(
    input  logic       chr_valid,
    input  logic [7:0] chr_data,
    input  logic       chr_ferr,
    output logic       ev_flag,
    output logic       ev_byte,
    output logic       ev_ferr
);
    logic clean;

    always_comb begin
        clean   = chr_valid && !chr_ferr;
        ev_flag = clean && (chr_data == FLAG_CHAR);
        ev_byte = clean && (chr_data != FLAG_CHAR);
        ev_ferr = chr_valid && chr_ferr;
    end
endmodule

// File: rtl/afr_fsm.sv
module afr_fsm
    import afr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier_ok,
    input  logic       ev_flag,
    input  logic       ev_byte,
    input  logic       ev_ferr,
    output afr_state_e state,
    output logic       cnt_clr,
    output logic       do_write,
    output logic       do_close,
    output logic       close_cd,
    output logic       close_fr
);
    afr_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        do_write = 1'b0;
        do_close = 1'b0;
        close_cd = 1'b0;
        close_fr = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (carrier_ok && ev_flag) begin
                    state_nx = ST_OPEN;
                    cnt_clr  = 1'b1;
                end
            end
            ST_OPEN: begin
                if (!carrier_ok || ev_ferr) begin
                    state_nx = ST_HUNT;
                end else if (ev_byte) begin
                    state_nx = ST_DATA;
                    do_write = 1'b1;
                end
            end
            ST_DATA: begin
                if (!carrier_ok) begin
                    state_nx = ST_HUNT;
                    do_close = 1'b1;
                    close_cd = 1'b1;
                end else if (ev_ferr) begin
                    state_nx = ST_HUNT;
                    do_close = 1'b1;
                    close_fr = 1'b1;
                end else if (ev_flag) begin
                    state_nx = ST_OPEN;
                    do_close = 1'b1;
                    cnt_clr  = 1'b1;
                end else if (ev_byte) begin
                    do_write = 1'b1;
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    // R2: leaving hunt requires a clean flag with carrier
    p_hunt_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT && !(carrier_ok && ev_flag)) |=> state == ST_HUNT);
endmodule

// File: rtl/afr_writer.sv
module afr_writer #(
    parameter int AW = 10,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_clr,
    input  logic          do_write,
    input  logic [7:0]    byte_in,
    input  logic          do_close,
    input  logic          close_cd,
    input  logic          close_fr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done,
    output logic [CW-1:0] done_count,
    output logic          done_cd_err,
    output logic          done_fr_err
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            done        <= 1'b0;
            done_count  <= '0;
            done_cd_err <= 1'b0;
            done_fr_err <= 1'b0;
        end else begin
            wr_en       <= do_write;
            done        <= do_close;
            done_cd_err <= do_close && close_cd;
            done_fr_err <= do_close && close_fr;
            if (do_write) begin
                wr_addr <= cnt[AW-1:0];
                wr_data <= byte_in;
            end
            if (do_close) done_count <= cnt;
            if (cnt_clr)       cnt <= '0;
            else if (do_write) cnt <= cnt + 1'b1;
        end
    end

    // R4: back-to-back writes use consecutive addresses
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!wr_en || wr_addr == $past(wr_addr) + 1'b1));
    // R12: done is a single-cycle pulse
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R12: error flags exclusive and only with done
    p_err_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_cd_err, done_fr_err}) && (done || !(done_cd_err || done_fr_err)));
endmodule

// File: rtl/afr_rx.sv
module afr_rx
    import afr_pkg::*;
#(
    parameter int BUF_DEPTH = 1024,
    parameter int CW        = 16,
    localparam int AW       = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chr_valid,
    input  logic [7:0]    chr_data,
    input  logic          chr_ferr,
    input  logic [2:0]    chr_votes,
    input  logic          carrier_ok,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          done,
    output logic [CW-1:0] done_count,
    output logic          done_cd_err,
    output logic          done_fr_err
);
    logic       ev_flag, ev_byte, ev_ferr;
    logic       cnt_clr, do_write, do_close, close_cd, close_fr;
    afr_state_e state;

    afr_classify u_classify (
        .chr_valid (chr_valid),
        .chr_data  (chr_data),
        .chr_ferr  (chr_ferr),
        .ev_flag   (ev_flag),
        .ev_byte   (ev_byte),
        .ev_ferr   (ev_ferr)
    );

    afr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .carrier_ok (carrier_ok),
        .ev_flag    (ev_flag),
        .ev_byte    (ev_byte),
        .ev_ferr    (ev_ferr),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .do_write   (do_write),
        .do_close   (do_close),
        .close_cd   (close_cd),
        .close_fr   (close_fr)
    );

    afr_writer #(.AW(AW), .CW(CW)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_clr     (cnt_clr),
        .do_write    (do_write),
        .byte_in     (chr_data),
        .do_close    (do_close),
        .close_cd    (close_cd),
        .close_fr    (close_fr),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .done        (done),
        .done_count  (done_count),
        .done_cd_err (done_cd_err),
        .done_fr_err (done_fr_err)
    );

    // R9: a character with a framing error is never written
    p_ferr_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && chr_ferr) |=> !wr_en);
    // R8: no write follows a cycle without carrier
    p_cd_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_ok |=> !wr_en);
    // R7: a data byte with disagreeing votes is still written
    p_votes_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && carrier_ok && chr_valid && !chr_ferr &&
         chr_data != FLAG_CHAR && !((&chr_votes) || !(|chr_votes)))
        |=> (wr_en && wr_data == $past(chr_data)));
endmodule

// File: tb/afr_rx_bench.sv
module afr_rx_bench;
    localparam int AW = 10;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chr_valid = 1'b0;
    logic [7:0]    chr_data = '0;
    logic          chr_ferr = 1'b0;
    logic [2:0]    chr_votes = '0;
    logic          carrier_ok = 1'b1;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          done;
    logic [CW-1:0] done_count;
    logic          done_cd_err, done_fr_err;

    always #2 clk = ~clk;

    afr_rx #(.BUF_DEPTH(1024), .CW(CW)) u_afr_rx (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_ferr(chr_ferr), .chr_votes(chr_votes), .carrier_ok(carrier_ok),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .done_count(done_count), .done_cd_err(done_cd_err), .done_fr_err(done_fr_err)
    );

    typedef struct {
        logic          wr;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          dn;
        logic [CW-1:0] cnt;
        logic          cd;
        logic          fr;
        string         req;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   m_state = 0;
    int   m_cnt = 0;
    bit   finished = 0;

    task automatic step(input logic v, input logic [7:0] d, input logic fe,
                        input logic [2:0] vt, input logic cr, input string req);
        exp_t e;
        logic is_flag, is_byte, is_ferr;
        e.wr = 0; e.addr = '0; e.data = '0; e.dn = 0; e.cnt = '0; e.cd = 0; e.fr = 0;
        e.req = req;
        is_flag = v && !fe && d == 8'h7E;
        is_byte = v && !fe && d != 8'h7E;
        is_ferr = v && fe;
        case (m_state)
            0: if (cr && is_flag) begin m_state = 1; m_cnt = 0; end
            1: if (!cr || is_ferr) m_state = 0;
               else if (is_byte) begin
                   e.wr = 1; e.addr = m_cnt[AW-1:0]; e.data = d; m_cnt++; m_state = 2;
               end
            default: if (!cr) begin
                   e.dn = 1; e.cnt = m_cnt[CW-1:0]; e.cd = 1; m_state = 0;
               end else if (is_ferr) begin
                   e.dn = 1; e.cnt = m_cnt[CW-1:0]; e.fr = 1; m_state = 0;
               end else if (is_flag) begin
                   e.dn = 1; e.cnt = m_cnt[CW-1:0]; m_state = 1; m_cnt = 0;
               end else if (is_byte) begin
                   e.wr = 1; e.addr = m_cnt[AW-1:0]; e.data = d; m_cnt++;
               end
        endcase
        chr_valid = v; chr_data = d; chr_ferr = fe; chr_votes = vt; carrier_ok = cr;
        @(posedge clk);
        q.push_back(e);
        @(negedge clk);
        chr_valid = 0; chr_ferr = 0;
    endtask

    task automatic ch(input logic [7:0] d, input string req);
        step(1'b1, d, 1'b0, 3'b111, 1'b1, req);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (wr_en !== e.wr || done !== e.dn ||
                (e.wr && (wr_addr !== e.addr || wr_data !== e.data)) ||
                (e.dn && done_count !== e.cnt) ||
                done_cd_err !== e.cd || done_fr_err !== e.fr) begin
                n_bad++;
                $display("FAIL %s: got wr=%0b addr=%0d data=%02h done=%0b cnt=%0d cd=%0b fr=%0b, expected wr=%0b addr=%0d data=%02h done=%0b cnt=%0d cd=%0b fr=%0b",
                         e.req, wr_en, wr_addr, wr_data, done, done_count, done_cd_err, done_fr_err,
                         e.wr, e.addr, e.data, e.dn, e.cnt, e.cd, e.fr);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (wr_en !== 0 || done !== 0 || done_count !== 0 || done_cd_err !== 0 || done_fr_err !== 0) begin
            n_bad++;
            $display("FAIL R1: got wr=%0b done=%0b cnt=%0d cd=%0b fr=%0b, expected all 0",
                     wr_en, done, done_count, done_cd_err, done_fr_err);
        end
        // R2: data in hunt ignored
        ch(8'h41, "R2"); ch(8'h42, "R2");
        // R3: back-to-back flags, then R4/R5 frame
        ch(8'h7E, "R3"); ch(8'h7E, "R3"); ch(8'h7E, "R3");
        ch(8'h11, "R4"); ch(8'h22, "R4"); ch(8'h33, "R4");
        ch(8'h7E, "R5");
        // R6: shared flag starts next frame at address 0
        ch(8'hA5, "R6"); ch(8'h5A, "R6");
        // R7: disagreeing votes accepted
        step(1'b1, 8'hC3, 1'b0, 3'b010, 1'b1, "R7");
        step(1'b1, 8'h3C, 1'b0, 3'b101, 1'b1, "R7");
        ch(8'h7E, "R6");
        // R8: carrier loss with a character in the same cycle
        ch(8'h01, "R8"); ch(8'h02, "R8");
        step(1'b1, 8'h03, 1'b0, 3'b111, 1'b0, "R8");
        step(1'b0, 8'h00, 1'b0, 3'b000, 1'b0, "R8");
        // R11: flag ignored without carrier
        step(1'b1, 8'h7E, 1'b0, 3'b111, 1'b0, "R11");
        step(1'b1, 8'h55, 1'b0, 3'b111, 1'b1, "R11");
        // R9: framing error closes frame, char discarded
        ch(8'h7E, "R9"); ch(8'h10, "R9");
        step(1'b1, 8'h20, 1'b1, 3'b111, 1'b1, "R9");
        // R2: data after error ignored until flag
        ch(8'h30, "R2"); ch(8'h31, "R2");
        // R9: framing error in open state, no report
        ch(8'h7E, "R9");
        step(1'b1, 8'h7E, 1'b1, 3'b111, 1'b1, "R9");
        ch(8'h44, "R2");
        // R10: long frame
        ch(8'h7E, "R10");
        for (int i = 0; i < 300; i++) ch(8'((i % 100) + 1), "R10");
        ch(8'h7E, "R10");
        // R12: idle cycles after a close show no further done
        step(1'b0, 8'h00, 1'b0, 3'b000, 1'b1, "R12");
        step(1'b0, 8'h00, 1'b0, 3'b000, 1'b1, "R12");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R12: got %0d unchecked items, expected 0", q.size());
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule